// File: doc/BRIEF.md
# Peripheral Port Control-Line Logic

This block serves one 8-bit peripheral port together with its two control lines. Each port pin has a direction bit that makes it an input or an output. Output pins drive the value held in the port data register. When the port data is read, input pins return either the live synchronised pin level or a copy captured on the active edge of the first control line. The first control line is always an edge-detected input, and a control bit picks which edge is active. The second control line follows a 3-bit mode. It can be an edge input that raises a flag, or it can be driven as a handshake output, a pulse output or a static low or high level.

The block does not store interrupt flags. It emits one-cycle set requests and clear requests for the two control-line flags, and a separate flag/enable block consumes them. An access to the normal data address clears flags as a side effect and steps the handshake. An access to the alternate data address reaches the same data register with no side effects. Register accesses arrive as decoded single-cycle read and write strobes with a 2-bit address:

| Address | Register |
| --- | --- |
| 0 | Data, with side effects |
| 1 | Direction |
| 2 | Control |
| 3 | Data, without side effects |

Read data is registered.

Top module: `port_cl_ctrl`

## Requirements
- R1: On the clock edge where synchronous reset is high, the following values are set: `pins_out` = 0, `pins_oe` = 0, `reg_rdata` = 0, `cl2_out` = 1, `cl2_oe` = 0, and all four flag request outputs = 0. The control register is cleared to 0.
- R2: A write to address 1 loads the direction register, which drives `pins_oe`, with 1 meaning output. A write to address 0 or address 3 loads the data register, which drives `pins_out`. Both take effect one clock after the write strobe.
- R3: Control bit 0 selects the active edge of the first control line: 0 is falling and 1 is rising. Each active edge gives a one-cycle `cl1_flag_set` pulse. The pulse rises on the third clock edge that samples the new line level.
- R4: Control bits 3:1 hold the second-line mode. Modes 000 and 001 flag a falling edge, and modes 010 and 011 flag a rising edge. The `cl2_flag_set` pulse has the same latency as in R3. Modes with bit 3 set never raise `cl2_flag_set`.
- R5: A read or write at address 0 gives a `cl1_flag_clr` pulse on the next cycle. In modes 000 and 010, the same access also gives `cl2_flag_clr`.
- R6: In modes 001 and 011, a data access never raises `cl2_flag_clr`. An access at address 3 raises neither clear request and does not disturb the second-line output.
- R7: A read at address 0 or 3 returns the data register on output bits. On input bits it returns the synchronised pin level when control bit 4 is 0. When control bit 4 is 1, input bits return the pin value captured at the most recent active edge of the first line.
- R8: `cl2_oe` is 1 exactly when control bit 3 is 1. Mode 110 drives `cl2_out` low and mode 111 drives it high, one cycle after the mode is in place.
- R9: In mode 101, `cl2_out` is low for exactly the one cycle after an access at address 0, and high otherwise.
- R10: In mode 100, `cl2_out` goes low after an access at address 0 and stays low until an active edge of the first line returns it high. If both happen in the same cycle, the access wins.
- R11: `reg_rdata` updates one clock after a read strobe and holds otherwise. Address 1 reads back the direction register, and address 2 reads back the 5-bit control register, zero-extended.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Registered read data |
| pins_in | input | WIDTH | Port pin levels |
| pins_out | output | WIDTH | Port output values |
| pins_oe | output | WIDTH | Per-pin output enable |
| cl1_in | input | 1 | First control line |
| cl2_in | input | 1 | Second control line, input level |
| cl2_out | output | 1 | Second control line, driven level |
| cl2_oe | output | 1 | Second control line, output enable |
| cl1_flag_set | output | 1 | First-line flag set request |
| cl1_flag_clr | output | 1 | First-line flag clear request |
| cl2_flag_set | output | 1 | Second-line flag set request |
| cl2_flag_clr | output | 1 | Second-line flag clear request |

## Verification
The properties assume the following about the inputs:
- Read and write strobes are never high together.
- Both control lines sit high while reset is applied, because the synchronisers come out of reset at that idle level.
- The control register is not rewritten in the same cycle that a control-line edge is being detected.

The stimulus keeps within these limits. It drives every input on the falling clock edge, issues one strobe at a time, holds the lines high across reset, and leaves several quiet cycles around each configuration write before toggling a control line.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  typedef enum logic [1:0] {
    ADDR_DATA       = 2'd0,
    ADDR_DIR        = 2'd1,
    ADDR_CTRL       = 2'd2,
    ADDR_DATA_QUIET = 2'd3
  } pcl_addr_e;

  typedef enum logic [2:0] {
    CL2_IN_FALL_CLR = 3'b000,
    CL2_IN_FALL_IND = 3'b001,
    CL2_IN_RISE_CLR = 3'b010,
    CL2_IN_RISE_IND = 3'b011,
    CL2_HANDSHAKE   = 3'b100,
    CL2_PULSE       = 3'b101,
    CL2_LOW         = 3'b110,
    CL2_HIGH        = 3'b111
  } cl2_mode_e;

  // bit 4: input capture enable, bits 3:1: second-line mode, bit 0: first-line rising edge
  typedef struct packed {
    logic      latch_en;
    cl2_mode_e cl2_mode;
    logic      cl1_rise;
  } ctrl_t;

endpackage

// File: rtl/pcl_edge_sync.sv
module pcl_edge_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              level;

  assign level = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{IDLE}};
      prev_q  <= IDLE;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= level;
    end
  end

  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;

endmodule

// File: rtl/pcl_port_in.sv
module pcl_port_in #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             capture_i,
  output logic [WIDTH-1:0] live_o,
  output logic [WIDTH-1:0] held_o
);

  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;

  assign live_o = chain_q[CHAIN_W-1 -: WIDTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      held_o  <= '0;
    end else begin
      chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], pins_i};
      if (capture_i) held_o <= live_o;
    end
  end

endmodule

// File: rtl/pcl_cl2_drive.sv
module pcl_cl2_drive
  import pcl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cl2_mode_e mode_i,
  input  logic      hs_access_i,
  input  logic      cl1_edge_i,
  output logic      line_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= 1'b1;
    end else begin
      case (mode_i)
        CL2_LOW:   line_o <= 1'b0;
        CL2_HIGH:  line_o <= 1'b1;
        CL2_PULSE: line_o <= ~hs_access_i;
        CL2_HANDSHAKE: begin
          if (hs_access_i)     line_o <= 1'b0;
          else if (cl1_edge_i) line_o <= 1'b1;
        end
        default:   line_o <= 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/port_cl_ctrl.sv
module port_cl_ctrl
  import pcl_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pins_in,
  output logic [WIDTH-1:0] pins_out,
  output logic [WIDTH-1:0] pins_oe,
  input  logic             cl1_in,
  input  logic             cl2_in,
  output logic             cl2_out,
  output logic             cl2_oe,
  output logic             cl1_flag_set,
  output logic             cl1_flag_clr,
  output logic             cl2_flag_set,
  output logic             cl2_flag_clr
);

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int N_LINES = 2;

  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;

  // control-line synchronisers: index 0 is the first line, 1 the second
  logic [N_LINES-1:0] line_in;
  logic [N_LINES-1:0] line_rise;
  logic [N_LINES-1:0] line_fall;

  assign line_in = {cl2_in, cl1_in};

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    pcl_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) sync_i (
      .clk    (clk),
      .rst    (rst),
      .line_i (line_in[i]),
      .rise_o (line_rise[i]),
      .fall_o (line_fall[i])
    );
  end

  logic cl1_edge;
  logic cl2_edge;
  logic cl2_is_out;

  assign cl1_edge   = ctrl_q.cl1_rise       ? line_rise[0] : line_fall[0];
  assign cl2_edge   = ctrl_q.cl2_mode[1]    ? line_rise[1] : line_fall[1];
  assign cl2_is_out = ctrl_q.cl2_mode[2];

  // register access decode
  pcl_addr_e sel;
  logic      hs_access;
  logic      data_wr;

  assign sel       = pcl_addr_e'(reg_addr);
  assign hs_access = (reg_wr | reg_rd) && (sel == ADDR_DATA);
  assign data_wr   = reg_wr && ((sel == ADDR_DATA) || (sel == ADDR_DATA_QUIET));

  // port input path
  logic [WIDTH-1:0] pin_live;
  logic [WIDTH-1:0] pin_held;

  pcl_port_in #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) port_in_i (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (pins_in),
    .capture_i (cl1_edge),
    .live_o    (pin_live),
    .held_o    (pin_held)
  );

  logic [WIDTH-1:0] din_sel;
  logic [WIDTH-1:0] rd_val;

  assign din_sel = ctrl_q.latch_en ? pin_held : pin_live;

  always_comb begin
    case (sel)
      ADDR_DATA, ADDR_DATA_QUIET: rd_val = (data_q & dir_q) | (din_sel & ~dir_q);
      ADDR_DIR:                   rd_val = dir_q;
      default:                    rd_val = {{(WIDTH-CTRL_W){1'b0}}, ctrl_q};
    endcase
  end

  // registers
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      dir_q     <= '0;
      ctrl_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (data_wr)                     data_q <= reg_wdata;
      if (reg_wr && sel == ADDR_DIR)   dir_q  <= reg_wdata;
      if (reg_wr && sel == ADDR_CTRL)  ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_rd)                      reg_rdata <= rd_val;
    end
  end

  // flag requests
  always_ff @(posedge clk) begin
    if (rst) begin
      cl1_flag_set <= 1'b0;
      cl1_flag_clr <= 1'b0;
      cl2_flag_set <= 1'b0;
      cl2_flag_clr <= 1'b0;
    end else begin
      cl1_flag_set <= cl1_edge;
      cl1_flag_clr <= hs_access;
      cl2_flag_set <= cl2_edge & ~cl2_is_out;
      cl2_flag_clr <= hs_access & ~cl2_is_out & ~ctrl_q.cl2_mode[0];
    end
  end

  pcl_cl2_drive cl2_drive_i (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (ctrl_q.cl2_mode),
    .hs_access_i (hs_access),
    .cl1_edge_i  (cl1_edge),
    .line_o      (cl2_out)
  );

  assign pins_out = data_q;
  assign pins_oe  = dir_q;
  assign cl2_oe   = cl2_is_out;

endmodule

// File: rtl/port_cl_ctrl_chk.sv
module port_cl_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic [4:0] ctrl_bits,
  input logic       cl1_flag_clr,
  input logic       cl2_flag_set,
  input logic       cl2_flag_clr,
  input logic       cl2_out,
  input logic       cl2_oe
);

  assert_hs_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr || reg_rd) && reg_addr == 2'd0) |=> cl1_flag_clr);

  assert_quiet_noclr_R6: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr || reg_rd) && reg_addr == 2'd3) |=> (!cl1_flag_clr && !cl2_flag_clr));

  assert_indep_noclr_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_bits[3] && ctrl_bits[1]) |=> !cl2_flag_clr);

  assert_out_noset_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_bits[3] |=> !cl2_flag_set);

  assert_static_low_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits[3:1] == 3'b110) |=> (!cl2_out && cl2_oe));

  assert_static_high_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits[3:1] == 3'b111) |=> (cl2_out && cl2_oe));

  assert_pulse_low_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits[3:1] == 3'b101 && (reg_wr || reg_rd) && reg_addr == 2'd0) |=> !cl2_out);

  assert_hs_low_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits[3:1] == 3'b100 && (reg_wr || reg_rd) && reg_addr == 2'd0) |=> !cl2_out);

endmodule

bind port_cl_ctrl port_cl_ctrl_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .ctrl_bits    (ctrl_q),
  .cl1_flag_clr (cl1_flag_clr),
  .cl2_flag_set (cl2_flag_set),
  .cl2_flag_clr (cl2_flag_clr),
  .cl2_out      (cl2_out),
  .cl2_oe       (cl2_oe)
);

// File: tb/port_cl_ctrl_tb_top.sv
`timescale 1ns/100ps
module port_cl_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] pins_in = 8'h00;
  logic [7:0] pins_out;
  logic [7:0] pins_oe;
  logic       cl1_in = 1'b1;
  logic       cl2_in = 1'b1;
  logic       cl2_out;
  logic       cl2_oe;
  logic       cl1_flag_set;
  logic       cl1_flag_clr;
  logic       cl2_flag_set;
  logic       cl2_flag_clr;

  always #2.5 clk = ~clk;

  port_cl_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins_in(pins_in),
    .pins_out(pins_out), .pins_oe(pins_oe), .cl1_in(cl1_in), .cl2_in(cl2_in),
    .cl2_out(cl2_out), .cl2_oe(cl2_oe), .cl1_flag_set(cl1_flag_set),
    .cl1_flag_clr(cl1_flag_clr), .cl2_flag_set(cl2_flag_set), .cl2_flag_clr(cl2_flag_clr)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  bit  model_live = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced at each rising edge
  logic [7:0] m_out = 0, m_dir = 0, m_rdata = 0, m_latch = 0, m_din = 0;
  logic [4:0] m_ctrl = 0;
  logic       m_set1 = 0, m_set2 = 0, m_clr1 = 0, m_clr2 = 0, m_cl2o = 1;
  logic       e1, e2, acc0, sel_data;
  logic [2:0] md;
  bit         hq1[$];
  bit         hq2[$];
  logic [7:0] pq[$];

  always @(posedge clk) begin
    if (rst) begin
      model_live = 1'b1;
      m_out = 0; m_dir = 0; m_rdata = 0; m_latch = 0; m_ctrl = 0;
      m_set1 = 0; m_set2 = 0; m_clr1 = 0; m_clr2 = 0; m_cl2o = 1;
      hq1 = '{1'b1, 1'b1, 1'b1};
      hq2 = '{1'b1, 1'b1, 1'b1};
      pq  = '{8'h00, 8'h00};
    end else begin
      md   = m_ctrl[3:1];
      e1   = m_ctrl[0] ? (hq1[1] && !hq1[2]) : (!hq1[1] && hq1[2]);
      e2   = md[1]     ? (hq2[1] && !hq2[2]) : (!hq2[1] && hq2[2]);
      acc0 = (reg_wr || reg_rd) && reg_addr == 2'd0;
      sel_data = (reg_addr == 2'd0) || (reg_addr == 2'd3);
      if (reg_rd) begin
        m_din = m_ctrl[4] ? m_latch : pq[1];
        if (sel_data)              m_rdata = (m_out & m_dir) | (m_din & ~m_dir);
        else if (reg_addr == 2'd1) m_rdata = m_dir;
        else                       m_rdata = {3'b000, m_ctrl};
      end
      case (md)
        3'b110:  m_cl2o = 1'b0;
        3'b111:  m_cl2o = 1'b1;
        3'b101:  m_cl2o = !acc0;
        3'b100:  m_cl2o = acc0 ? 1'b0 : (e1 ? 1'b1 : m_cl2o);
        default: m_cl2o = 1'b1;
      endcase
      m_set1 = e1;
      m_set2 = e2 && !md[2];
      m_clr1 = acc0;
      m_clr2 = acc0 && !md[2] && !md[0];
      if (e1) m_latch = pq[1];
      if (reg_wr) begin
        if (sel_data)              m_out  = reg_wdata;
        else if (reg_addr == 2'd1) m_dir  = reg_wdata;
        else                       m_ctrl = reg_wdata[4:0];
      end
      hq1.push_front(cl1_in); void'(hq1.pop_back());
      hq2.push_front(cl2_in); void'(hq2.pop_back());
      pq.push_front(pins_in); void'(pq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_live && !done) begin
      chk("R2 pins_out", pins_out, m_out);
      chk("R2 pins_oe", pins_oe, m_dir);
      chk("R3 cl1_flag_set", cl1_flag_set, m_set1);
      chk("R4 cl2_flag_set", cl2_flag_set, m_set2);
      chk("R5 cl1_flag_clr", cl1_flag_clr, m_clr1);
      chk("R5/R6 cl2_flag_clr", cl2_flag_clr, m_clr2);
      chk("R8/R9/R10 cl2_out", cl2_out, m_cl2o);
      chk("R8 cl2_oe", cl2_oe, m_ctrl[3]);
      chk("R7/R11 reg_rdata", reg_rdata, m_rdata);
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    // R1 reset values
    chk("R1 pins_oe", pins_oe, 8'h00);
    chk("R1 pins_out", pins_out, 8'h00);
    chk("R1 cl2_out", cl2_out, 1'b1);
    chk("R1 cl2_oe", cl2_oe, 1'b0);
    chk("R1 flags", {cl1_flag_set, cl1_flag_clr, cl2_flag_set, cl2_flag_clr}, 4'h0);
    chk("R1 reg_rdata", reg_rdata, 8'h00);
    rst = 1'b0;
    idle(2);

    // R2 direction and data through both data addresses
    wr_reg(2'd1, 8'hF0);
    wr_reg(2'd0, 8'hA5);
    chk("R2 pins_oe", pins_oe, 8'hF0);
    chk("R2 pins_out", pins_out, 8'hA5);
    wr_reg(2'd3, 8'h3C);
    chk("R2 quiet write", pins_out, 8'h3C);
    chk("R6 quiet write clr", cl1_flag_clr, 1'b0);

    // R3 rising first line, R4 mode 000 falling second line
    wr_reg(2'd2, 8'h01);
    idle(3);
    cl1_in = 1'b0; idle(5);
    cl1_in = 1'b1; idle(5);
    cl2_in = 1'b0; idle(5);
    cl2_in = 1'b1; idle(5);

    // R7 live read, R5 clears in mode 000
    pins_in = 8'h5A; idle(4);
    rd_reg(2'd0);
    chk("R7 live read", reg_rdata, 8'h3A);
    chk("R5 cl1 clear", cl1_flag_clr, 1'b1);
    chk("R5 cl2 clear mode 000", cl2_flag_clr, 1'b1);
    rd_reg(2'd3);
    chk("R6 quiet read no clear", cl1_flag_clr, 1'b0);
    chk("R6 quiet read data", reg_rdata, 8'h3A);

    // R6 independent falling mode 001
    wr_reg(2'd2, 8'h03);
    idle(3);
    cl2_in = 1'b0; idle(5);
    cl2_in = 1'b1; idle(5);
    rd_reg(2'd0);
    chk("R6 independent no cl2 clear", cl2_flag_clr, 1'b0);
    // R4 rising second line, modes 010 and 011
    wr_reg(2'd2, 8'h05);
    idle(3);
    cl2_in = 1'b0; idle(5);
    cl2_in = 1'b1; idle(5);
    wr_reg(2'd2, 8'h07);
    idle(3);
    cl2_in = 1'b0; idle(5);
    cl2_in = 1'b1; idle(5);
    wr_reg(2'd0, 8'h3C);

    // R7 input capture on rising first-line edge
    wr_reg(2'd2, 8'h11);
    pins_in = 8'h0F; idle(4);
    cl1_in = 1'b0; idle(5);
    cl1_in = 1'b1; idle(5);
    pins_in = 8'hF0; idle(5);
    rd_reg(2'd0);
    chk("R7 captured read", reg_rdata, 8'h3F);
    wr_reg(2'd2, 8'h01);
    rd_reg(2'd0);
    chk("R7 live after capture off", reg_rdata, 8'h30);

    // R8 static levels
    wr_reg(2'd2, 8'h0D);
    idle(1);
    chk("R8 static low", cl2_out, 1'b0);
    chk("R8 oe in output mode", cl2_oe, 1'b1);
    cl2_in = 1'b0; idle(5);
    cl2_in = 1'b1; idle(5);
    wr_reg(2'd2, 8'h0F);
    idle(1);
    chk("R8 static high", cl2_out, 1'b1);

    // R9 pulse output
    wr_reg(2'd2, 8'h0B);
    idle(2);
    wr_reg(2'd0, 8'h55);
    chk("R9 pulse low", cl2_out, 1'b0);
    idle(1);
    chk("R9 pulse back high", cl2_out, 1'b1);
    wr_reg(2'd3, 8'h66);
    chk("R6 quiet write no pulse", cl2_out, 1'b1);
    rd_reg(2'd0);
    chk("R9 pulse on read", cl2_out, 1'b0);
    idle(3);

    // R10 handshake
    wr_reg(2'd2, 8'h09);
    idle(2);
    rd_reg(2'd0);
    chk("R10 handshake low", cl2_out, 1'b0);
    idle(3);
    chk("R10 handshake held", cl2_out, 1'b0);
    cl1_in = 1'b0; idle(5);
    chk("R10 inactive edge ignored", cl2_out, 1'b0);
    cl1_in = 1'b1; idle(4);
    chk("R10 handshake released", cl2_out, 1'b1);
    rd_reg(2'd3);
    chk("R6 quiet read keeps handshake", cl2_out, 1'b1);
    idle(3);

    // R3 falling edge selected
    wr_reg(2'd2, 8'h00);
    idle(3);
    cl1_in = 1'b0; idle(5);
    cl1_in = 1'b1; idle(5);

    // R11 readback
    rd_reg(2'd1);
    chk("R11 dir readback", reg_rdata, 8'hF0);
    wr_reg(2'd2, 8'h1B);
    rd_reg(2'd2);
    chk("R11 ctrl readback", reg_rdata, 8'h1B);
    idle(3);
    chk("R11 rdata holds", reg_rdata, 8'h1B);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule